// File: doc/BRIEF.md
# Watchdog Configuration Unlock Sequencer

This block watches bus writes aimed at a watchdog's unlock register and decides when the watchdog's write-once configuration registers may be written again. A software agent unlocks the configuration by writing two fixed key words in order. The second key must follow the first within a bounded number of bus clock cycles. A correct pair opens an update window whose length in cycles is taken from a configurable count. The surrounding configuration logic accepts register writes only while the window flag is high.

A wrong key, or a second key that comes too late, is treated as a fault. A fault raises a system reset request. When the interrupt-before-reset enable is set, the block first raises an interrupt request for a fixed number of cycles and only then raises the reset request. The reset request stays high until the block itself is reset. None of this has any effect unless the allow-update enable is set. The watchdog counter, the refresh logic and the configuration storage sit outside this block.

Top module: `wdog_unlock_seq`

## Requirements
- R1: With allow_upd high, a write of 0xC520 followed by a write of 0xD928 raises win_open in the cycle after the cycle that carries the 0xD928 write.
- R2: The second key is accepted when it is written d cycles after the first key, for any d from 1 to 20 inclusive.
- R3: If no write reaches the unlock register in the 20 cycles after the first key, a fault is taken at the end of the 20th cycle.
- R4: win_open stays high for exactly win_len cycles, where win_len is the value present in the cycle of the second key. A win_len of 0 opens no window and returns the sequencer to its idle state.
- R5: Each of these writes is a fault: any value other than 0xC520 while idle; any value other than 0xD928 (0xC520 included) after the first key; any value other than 0xC520 while the window is open.
- R6: On a fault with irq_first_en low, rst_req rises in the next cycle and irq_req stays low.
- R7: On a fault with irq_first_en high, irq_req rises in the next cycle and stays high for IRQ_DELAY cycles (256 by default). In the cycle after that, irq_req falls and rst_req rises.
- R8: Once high, rst_req stays high until rst_n is asserted. Writes made while rst_req or irq_req is high are ignored.
- R9: While allow_upd is low, writes to the unlock register are ignored: no window opens and no fault is taken.
- R10: A 0xC520 write while the window is open closes the window in the next cycle and restarts the check. A 0xD928 write that follows in time then reopens it.
- R11: A write counts only in a cycle where wr_en and wr_sel are both high. Data presented with either one low has no effect.
- R12: After reset, win_open, irq_req and rst_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 1 | High when the write addresses the unlock register |
| wr_data | input | 16 | Write data |
| allow_upd | input | 1 | Enables unlock sequencing |
| irq_first_en | input | 1 | On a fault, interrupt first and reset later |
| win_len | input | WIN_W (16) | Update window length in cycles |
| win_open | output | 1 | Configuration registers may be written |
| irq_req | output | 1 | Interrupt request that precedes a fault reset |
| rst_req | output | 1 | System reset request, held until reset |

## Verification
The assertions assume that every input is a known value that changes away from the rising clock edge, and that rst_n is asserted before any property matters. They also assume that irq_first_en is valid in the cycle where a fault is taken, since that cycle alone chooses between the two fault paths. The stimulus changes every input only on the falling edge. It holds wr_en and wr_sel low except in the single cycle of an intended write, and it changes irq_first_en and win_len only while no fault or key acceptance is pending. After every test that ends in rst_req, the stimulus brings the block back through rst_n.

// File: rtl/wdog_unlock_pkg.sv
package wdog_unlock_pkg;

  localparam logic [15:0] UNLOCK_KEY_A = 16'hC520;
  localparam logic [15:0] UNLOCK_KEY_B = 16'hD928;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIRST = 3'd1,
    ST_OPEN  = 3'd2,
    ST_IRQ   = 3'd3,
    ST_RESET = 3'd4
  } unlock_state_e;

  // Where a fault sends the sequencer.
  function automatic unlock_state_e fault_target(input logic irq_first);
    return irq_first ? ST_IRQ : ST_RESET;
  endfunction

endpackage

// File: rtl/wdog_key_match.sv
module wdog_key_match #(
  parameter int                  DATA_W     = 16,
  parameter logic [DATA_W-1:0]   KEY_FIRST  = 16'hC520,
  parameter logic [DATA_W-1:0]   KEY_SECOND = 16'hD928
) (
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              allow_upd,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic              is_first,
  output logic              is_second
);

  function automatic logic key_eq(input logic [DATA_W-1:0] d,
                                  input logic [DATA_W-1:0] k);
    return (d == k);
  endfunction

  assign hit       = wr_en & wr_sel & allow_upd;
  assign is_first  = key_eq(wr_data, KEY_FIRST);
  assign is_second = key_eq(wr_data, KEY_SECOND);

endmodule

// File: rtl/wdog_gap_timer.sv
module wdog_gap_timer #(
  parameter int LIMIT = 20,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         expired
);

  localparam logic [W-1:0] LIM = W'(LIMIT);

  // Saturating step so the count never leaves 0..LIMIT.
  function automatic logic [W-1:0] gap_step(input logic [W-1:0] c);
    if (c >= LIM) return LIM;
    return c + W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= W'(1);
    else if (run)  cnt <= gap_step(cnt);
  end

  assign expired = (cnt == LIM);

endmodule

// File: rtl/wdog_down_timer.sv
module wdog_down_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         last
);

  function automatic logic [W-1:0] down_step(input logic [W-1:0] c);
    if (c == '0) return '0;
    return c - W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= down_step(cnt);
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/wdog_unlock_seq.sv
module wdog_unlock_seq
  import wdog_unlock_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] KEY_FIRST  = UNLOCK_KEY_A,
  parameter logic [DATA_W-1:0] KEY_SECOND = UNLOCK_KEY_B,
  parameter int                GAP_LIMIT  = 20,
  parameter int                WIN_W      = 16,
  parameter int                IRQ_DELAY  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              allow_upd,
  input  logic              irq_first_en,
  input  logic [WIN_W-1:0]  win_len,
  output logic              win_open,
  output logic              irq_req,
  output logic              rst_req
);

  localparam int GAP_W = $clog2(GAP_LIMIT + 1);
  localparam int IRQ_W = $clog2(IRQ_DELAY + 1);
  localparam logic [IRQ_W-1:0] IRQ_LOAD = IRQ_W'(IRQ_DELAY);

  unlock_state_e state_q, state_d;

  logic             wr_hit, is_k1, is_k2;
  logic [GAP_W-1:0] gap_cnt;
  logic             gap_expired;
  logic [WIN_W-1:0] win_cnt;
  logic             win_last;
  logic [IRQ_W-1:0] irq_cnt;
  logic             irq_last;

  // Named internal events (also observed by the checker).
  logic seq_idle, seq_in_first, seq_open, seq_irq, seq_armed;
  logic ev_key1_ok, ev_key2_ok, ev_bad_key, ev_gap_expire, ev_fault;
  logic ev_win_done, ev_irq_done, ev_zero_win;

  wdog_key_match #(
    .DATA_W     (DATA_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_keys (
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .allow_upd (allow_upd),
    .wr_data   (wr_data),
    .hit       (wr_hit),
    .is_first  (is_k1),
    .is_second (is_k2)
  );

  assign seq_idle     = (state_q == ST_IDLE);
  assign seq_in_first = (state_q == ST_FIRST);
  assign seq_open     = (state_q == ST_OPEN);
  assign seq_irq      = (state_q == ST_IRQ);
  assign seq_armed    = seq_idle | seq_in_first | seq_open;

  assign ev_key1_ok    = wr_hit & is_k1 & (seq_idle | seq_open);
  assign ev_key2_ok    = wr_hit & is_k2 & seq_in_first;
  assign ev_bad_key    = wr_hit & seq_armed & ~ev_key1_ok & ~ev_key2_ok;
  assign ev_gap_expire = seq_in_first & ~wr_hit & gap_expired;
  assign ev_fault      = ev_bad_key | ev_gap_expire;
  assign ev_zero_win   = ev_key2_ok & (win_len == '0);
  assign ev_win_done   = seq_open & win_last;
  assign ev_irq_done   = seq_irq & irq_last;

  wdog_gap_timer #(
    .LIMIT (GAP_LIMIT),
    .W     (GAP_W)
  ) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_key1_ok),
    .run     (seq_in_first),
    .cnt     (gap_cnt),
    .expired (gap_expired)
  );

  wdog_down_timer #(
    .W (WIN_W)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_key2_ok),
    .load_val (win_len),
    .run      (seq_open),
    .cnt      (win_cnt),
    .last     (win_last)
  );

  wdog_down_timer #(
    .W (IRQ_W)
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_fault & irq_first_en),
    .load_val (IRQ_LOAD),
    .run      (seq_irq),
    .cnt      (irq_cnt),
    .last     (irq_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_key1_ok)    state_d = ST_FIRST;
        else if (ev_fault) state_d = fault_target(irq_first_en);
      end
      ST_FIRST: begin
        if (ev_zero_win)     state_d = ST_IDLE;
        else if (ev_key2_ok) state_d = ST_OPEN;
        else if (ev_fault)   state_d = fault_target(irq_first_en);
      end
      ST_OPEN: begin
        if (ev_key1_ok)       state_d = ST_FIRST;
        else if (ev_fault)    state_d = fault_target(irq_first_en);
        else if (ev_win_done) state_d = ST_IDLE;
      end
      ST_IRQ: begin
        if (ev_irq_done) state_d = ST_RESET;
      end
      ST_RESET: state_d = ST_RESET;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign win_open = seq_open;
  assign irq_req  = seq_irq;
  assign rst_req  = (state_q == ST_RESET);

endmodule

// File: rtl/wdog_unlock_chk.sv
module wdog_unlock_chk #(
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'hD928,
  parameter int                GAP_LIMIT  = 20,
  parameter int                GAP_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              allow_upd,
  input logic              irq_first_en,
  input logic              win_open,
  input logic              irq_req,
  input logic              rst_req,
  input logic              seq_in_first,
  input logic [GAP_W-1:0]  gap_cnt,
  input logic              ev_fault
);

  // R1: a window only opens right after a second-key write.
  a_r1_open_follows_key2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(wr_en && wr_sel && wr_data == KEY_SECOND));

  // R2, R3: the gap count never leaves its range while waiting for key two.
  a_r2_gap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    seq_in_first |-> (gap_cnt >= GAP_W'(1) && gap_cnt <= GAP_W'(GAP_LIMIT)));

  // R6: a fault with the interrupt path off goes straight to reset.
  a_r6_direct_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fault && !irq_first_en) |=> (rst_req && !irq_req));

  // R7: a fault with the interrupt path on raises the interrupt first.
  a_r7_irq_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fault && irq_first_en) |=> (irq_req && !rst_req));

  // R7: reset is reached from the interrupt or from a direct fault only.
  a_r7_reset_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(irq_req) || $past(ev_fault && !irq_first_en)));

  // R8: the reset request holds until reset.
  a_r8_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R9: nothing opens while unlocking is disallowed.
  a_r9_locked_no_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(allow_upd));

  // R12: the three outputs are mutually exclusive.
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_open, irq_req, rst_req}));

endmodule

bind wdog_unlock_seq wdog_unlock_chk #(
  .DATA_W     (DATA_W),
  .KEY_SECOND (KEY_SECOND),
  .GAP_LIMIT  (GAP_LIMIT),
  .GAP_W      (GAP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .allow_upd    (allow_upd),
  .irq_first_en (irq_first_en),
  .win_open     (win_open),
  .irq_req      (irq_req),
  .rst_req      (rst_req),
  .seq_in_first (seq_in_first),
  .gap_cnt      (gap_cnt),
  .ev_fault     (ev_fault)
);

// File: tb/wdog_unlock_seq_bench.sv
`timescale 1ns/1ps
module wdog_unlock_seq_bench;

  localparam logic [15:0] K1 = 16'hC520;
  localparam logic [15:0] K2 = 16'hD928;
  localparam int GAP = 20;
  localparam int IRQ_DLY = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        allow_upd = 1'b1;
  logic        irq_first_en = 1'b0;
  logic [15:0] win_len = 16'd5;
  logic        win_open, irq_req, rst_req;

  always #2 clk = ~clk;

  wdog_unlock_seq u_wdog_unlock_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .allow_upd(allow_upd), .irq_first_en(irq_first_en),
    .win_len(win_len), .win_open(win_open), .irq_req(irq_req), .rst_req(rst_req)
  );

  // ---------------- behavioural reference model (time stamps) ----------
  localparam int M_IDLE = 0, M_FIRST = 1, M_OPEN = 2, M_IRQ = 3, M_RST = 4;
  int     m_mode = M_IDLE;
  longint cyc = 0, t_first = 0, t_close = 0, t_irq_end = 0;

  task automatic model_fault();
    if (irq_first_en) begin
      m_mode = M_IRQ;
      t_irq_end = cyc + IRQ_DLY;
    end else begin
      m_mode = M_RST;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_IDLE;
    end else begin
      bit hit;
      hit = wr_en && wr_sel && allow_upd;
      case (m_mode)
        M_IDLE:
          if (hit) begin
            if (wr_data == K1) begin m_mode = M_FIRST; t_first = cyc; end
            else model_fault();
          end
        M_FIRST:
          if (hit) begin
            if (wr_data == K2 && (cyc - t_first) <= GAP) begin
              if (win_len == 0) m_mode = M_IDLE;
              else begin m_mode = M_OPEN; t_close = cyc + win_len; end
            end else model_fault();
          end else if ((cyc - t_first) >= GAP) model_fault();
        M_OPEN:
          if (hit) begin
            if (wr_data == K1) begin m_mode = M_FIRST; t_first = cyc; end
            else model_fault();
          end else if (cyc >= t_close) m_mode = M_IDLE;
        M_IRQ:
          if (cyc >= t_irq_end) m_mode = M_RST;
        default: ;
      endcase
      cyc = cyc + 1;
    end
  end

  int mc_checks = 0, mc_fail = 0;
  always @(negedge clk) begin
    #1;
    mc_checks = mc_checks + 3;
    if (win_open !== (m_mode == M_OPEN)) begin
      mc_fail++;
      $display("FAIL R4 model win_open actual=%0d expected=%0d t=%0t", win_open, m_mode == M_OPEN, $time);
    end
    if (irq_req !== (m_mode == M_IRQ)) begin
      mc_fail++;
      $display("FAIL R7 model irq_req actual=%0d expected=%0d t=%0t", irq_req, m_mode == M_IRQ, $time);
    end
    if (rst_req !== (m_mode == M_RST)) begin
      mc_fail++;
      $display("FAIL R6 model rst_req actual=%0d expected=%0d t=%0t", rst_req, m_mode == M_RST, $time);
    end
  end

  // ---------------- directed checks ----------------
  int checks = 0, failures = 0;
  bit timed_out = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d, input logic sel = 1'b1, input logic en = 1'b1);
    @(negedge clk); wr_en = en; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  // first word, then second word d cycles later; returns one cycle after it
  task automatic two_keys(input logic [15:0] a, input logic [15:0] b, input int d);
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = a;
    for (int i = 1; i < d; i++) begin
      @(negedge clk); wr_en = 1'b0; wr_sel = 1'b0;
    end
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  function automatic int count_open_dummy(); return 0; endfunction

  task automatic count_high(input bit which_irq, output int n);
    n = 0;
    while ((which_irq ? irq_req : win_open) && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_tests();
    int n;
    do_reset();
    chk("R12 win_open after reset", win_open, 0);
    chk("R12 irq_req after reset", irq_req, 0);
    chk("R12 rst_req after reset", rst_req, 0);

    // R1 / R4: back-to-back keys, window of 5
    win_len = 16'd5;
    two_keys(K1, K2, 1);
    chk("R1 window opens after key pair", win_open, 1);
    count_high(0, n);
    chk("R4 window length 5", n, 5);
    chk("R4 no fault after window", rst_req, 0);

    // R2: gap exactly 20
    win_len = 16'd3;
    two_keys(K1, K2, GAP);
    chk("R2 gap of 20 accepted", win_open, 1);
    count_high(0, n);
    chk("R4 window length 3", n, 3);

    // R9: locked
    allow_upd = 1'b0;
    two_keys(K1, K2, 1);
    chk("R9 no window while locked", win_open, 0);
    wr(16'h1234);
    chk("R9 bad word ignored while locked", rst_req | irq_req, 0);
    allow_upd = 1'b1;

    // R11: partial strobes
    wr(16'hBEEF, 1'b0, 1'b1);
    chk("R11 write without select ignored", rst_req, 0);
    wr(16'hBEEF, 1'b1, 1'b0);
    chk("R11 select without write ignored", rst_req, 0);

    // R4: zero length window
    win_len = 16'd0;
    two_keys(K1, K2, 2);
    chk("R4 zero length opens nothing", win_open, 0);
    repeat (3) @(negedge clk);
    chk("R4 zero length no fault", rst_req, 0);
    win_len = 16'd2;
    two_keys(K1, K2, 1);
    count_high(0, n);
    chk("R4 idle after zero length, then window 2", n, 2);

    // R10: restart inside an open window
    win_len = 16'd50;
    two_keys(K1, K2, 1);
    repeat (3) @(negedge clk);
    win_len = 16'd4;
    wr(K1);
    chk("R10 first key closes window", win_open, 0);
    wr(K2);
    chk("R10 reopened by second key", win_open, 1);
    count_high(0, n);
    chk("R10 reopened window length 4", n, 4);

    // R3 / R6 / R8: timeout with direct reset
    irq_first_en = 1'b0;
    wr(K1);
    repeat (GAP - 1) @(negedge clk);
    chk("R3 no fault at gap 20", rst_req, 0);
    @(negedge clk);
    chk("R3 timeout fault -> R6 reset", rst_req, 1);
    chk("R6 no interrupt on direct path", irq_req, 0);
    two_keys(K1, K2, 1);
    chk("R8 reset sticky, writes ignored", rst_req, 1);
    chk("R8 no window while in reset", win_open, 0);
    do_reset();
    chk("R8 reset request cleared by rst_n", rst_req, 0);

    // R5 / R7: bad word while idle, interrupt first
    irq_first_en = 1'b1;
    wr(16'h1234);
    chk("R7 interrupt raised first", irq_req, 1);
    chk("R7 reset not yet raised", rst_req, 0);
    count_high(1, n);
    chk("R7 interrupt length", n, IRQ_DLY);
    chk("R7 reset after interrupt", rst_req, 1);
    do_reset();
    irq_first_en = 1'b0;

    // R5: first key repeated instead of second
    two_keys(K1, K1, 1);
    chk("R5 repeated first key is fault", rst_req, 1);
    do_reset();

    // R5: wrong word inside window
    win_len = 16'd20;
    two_keys(K1, K2, 1);
    @(negedge clk);
    wr(K2);
    chk("R5 second key inside window is fault", rst_req, 1);
    do_reset();

    // R2 / R3: gap of 21 is late
    two_keys(K1, K2, GAP + 1);
    chk("R2 gap of 21 rejected", win_open, 0);
    chk("R3 late key gives reset", rst_req, 1);
    do_reset();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mc_checks, failures + mc_fail);
    $finish;
  end

endmodule